// File: doc/BRIEF.md
# Two-Level Frame and Thread Scheduler

This block picks what a fine-grained threaded core runs next. Threads are grouped into activation frames, and each frame owns a small last-in, first-out stack of pending thread entry addresses. While a frame is current, forked threads are pushed onto its stack, and every stop pops the next address to run. Messages that reach a frame that is not current post a thread onto that frame's stack. The first such post since the frame last ran puts the frame on a first-in, first-out queue of runnable frames.

Scheduling has two levels. Threads are drawn from the current frame until its stack is empty. The bottom entry of every stack is the exit thread, loaded when the frame is allocated. That thread saves live state and issues a swap, which dequeues the next runnable frame and dispatches the top entry of that frame's stack. A swap that finds the queue empty leaves the scheduler idle. The next post that makes a frame runnable then dispatches that frame without any further command.

Commands enter on a valid/ready port. `cmd_ready` is low while a dispatched address waits on the output port and during the cycle of an automatic dispatch. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Dispatched addresses leave on a valid/ready port. `out_valid`, `out_pc` and `out_frame` are held stable until the edge on which `out_ready` is high. `idle` and `overflow` are plain status outputs.

Top module: `frame_sched`

## Requirements
- R1: After reset, `out_valid`, `idle` and `overflow` are low, `cmd_ready` is high, and no frame is current.
- R2: Opcode 1 (allocate) loads `cmd_pc` as the only entry of frame `cmd_frame`'s stack and clears that frame's queued mark. After all later-pushed entries of the frame have been dispatched, this exit address is dispatched last.
- R3: Opcode 2 (fork) pushes `cmd_pc` onto the current frame's stack. Opcode 3 (stop) pops the top of that stack and presents it on `out_pc` with `out_frame` set to the current frame in the cycle after acceptance, so the most recent push comes out first.
- R4: Opcode 4 (post) pushes `cmd_pc` onto frame `cmd_frame`'s stack. If that frame is not current and is not already queued, the post appends the frame to the runnable queue. Posting to an already queued frame does not enqueue it a second time.
- R5: Opcode 5 (swap) with a non-empty queue removes the oldest queued frame, makes it current, and dispatches the top entry of its stack in the cycle after acceptance.
- R6: A swap with an empty queue raises `idle` and leaves no frame current. While idle, the first post that enqueues a frame causes that frame to be dispatched one cycle after the post is accepted, and `idle` falls on the same edge.
- R7: A push (fork or post) to a stack already holding STACK_DEPTH entries is dropped, and `overflow` is high for the one cycle after that command.
- R8: A stop on an empty stack, or a stop or fork while no frame is current, produces no dispatch and changes no stack.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pc` and `out_frame` hold their values and `cmd_ready` stays low.
- R10: A post to the current frame pushes onto its stack without enqueuing it, so the next stop returns the posted address.
- R11: Opcodes 0, 6 and 7 are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 allocate, 2 fork, 3 stop, 4 post, 5 swap |
| cmd_frame | input | FID_W | Target frame for allocate and post |
| cmd_pc | input | PC_W | Thread address for allocate, fork and post |
| out_valid | output | 1 | Dispatched address present |
| out_ready | input | 1 | Consumer takes the dispatched address |
| out_pc | output | PC_W | Address of the thread to run |
| out_frame | output | FID_W | Frame that owns the dispatched thread |
| idle | output | 1 | A swap found no runnable frame |
| overflow | output | 1 | One-cycle pulse after a dropped push |

## Verification
On every cycle, the assertions check the output hold and back-pressure rules. They also check that the number of frames marked queued equals the queue occupancy, that a new dispatch never appears while `idle` remains high, and that `overflow` only follows an accepted command. Only the bench's scenarios can show the thread order: last-in, first-out within a frame and first-in, first-out across frames. The same holds for the exit address coming out last, for automatic dispatch after an idle post, and for stops and forks being ignored when there is nothing to act on.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_FALLOC = 3'd1,
    OP_FORK   = 3'd2,
    OP_STOP   = 3'd3,
    OP_POST   = 3'd4,
    OP_SWAP   = 3'd5
  } sched_op_e;
endpackage

// File: rtl/frame_stack.sv
module frame_stack #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic [PC_W-1:0] init_pc,
  input  logic            push,
  input  logic [PC_W-1:0] push_pc,
  input  logic            pop,
  output logic [PC_W-1:0] top_pc,
  output logic            empty,
  output logic            full
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PC_W-1:0]  mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] top_idx;

  assign empty   = (sp == '0);
  assign full    = (sp == SP_W'(DEPTH));
  assign top_idx = IDX_W'(sp - 1'b1);
  assign top_pc  = mem[top_idx];

  // depth pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (init) begin
      sp <= SP_W'(1);
    end else if (push && !full) begin
      sp <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp - 1'b1;
    end
  end

  // entry storage, no reset needed
  always_ff @(posedge clk) begin
    if (init) begin
      mem[0] <= init_pc;
    end else if (push && !full) begin
      mem[sp[IDX_W-1:0]] <= push_pc;
    end
  end
endmodule

// File: rtl/run_queue.sv
module run_queue #(
  parameter int NUM  = 4,
  parameter int ID_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enq,
  input  logic [ID_W-1:0]          enq_id,
  input  logic                     deq,
  output logic [ID_W-1:0]          head_id,
  output logic                     empty,
  output logic [$clog2(NUM+1)-1:0] count
);
  localparam int PTR_W = (NUM > 1) ? $clog2(NUM) : 1;
  localparam int CNT_W = $clog2(NUM + 1);

  logic [ID_W-1:0]  slots [NUM];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             do_enq, do_deq;

  assign empty   = (count == '0);
  assign do_enq  = enq && (count != CNT_W'(NUM));
  assign do_deq  = deq && !empty;
  assign head_id = slots[rd_ptr];

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_enq) wr_ptr <= wrap_inc(wr_ptr);
      if (do_deq) rd_ptr <= wrap_inc(rd_ptr);
      if (do_enq && !do_deq)      count <= count + 1'b1;
      else if (do_deq && !do_enq) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_enq) slots[wr_ptr] <= enq_id;
  end
endmodule

// File: rtl/frame_sched.sv
module frame_sched
  import sched_pkg::*;
#(
  parameter int NUM_FRAMES  = 4,
  parameter int STACK_DEPTH = 4,
  parameter int PC_W        = 16,
  localparam int FID_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [FID_W-1:0] cmd_frame,
  input  logic [PC_W-1:0]  cmd_pc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_pc,
  output logic [FID_W-1:0] out_frame,
  output logic             idle,
  output logic             overflow
);
  localparam int QC_W = $clog2(NUM_FRAMES + 1);
  localparam logic [FID_W:0] NF_L = (FID_W + 1)'(NUM_FRAMES);

  // state
  logic                  cur_valid_q;
  logic [FID_W-1:0]      cur_frame_q;
  logic                  idle_q;
  logic [NUM_FRAMES-1:0] queued_q;
  logic                  ovf_q;
  logic                  ov_q;
  logic [PC_W-1:0]       opc_q;
  logic [FID_W-1:0]      ofr_q;

  // per-frame stack wiring
  logic [NUM_FRAMES-1:0] st_init, st_push, st_pop, st_empty, st_full;
  logic [PC_W-1:0]       st_top [NUM_FRAMES];

  // queue wiring
  logic [FID_W-1:0] q_head;
  logic             q_empty;
  logic [QC_W-1:0]  q_count;

  // decode
  logic accept, frame_ok, do_auto;
  logic is_falloc, is_fork, is_stop, is_post, is_swap;
  logic take_q, swap_empty, post_enq, stop_ok, fork_ok;

  assign do_auto   = idle_q && !q_empty && !ov_q;
  assign cmd_ready = !ov_q && !do_auto;
  assign accept    = cmd_valid && cmd_ready;
  assign frame_ok  = ({1'b0, cmd_frame} < NF_L);

  assign is_falloc = accept && (cmd_op == OP_FALLOC) && frame_ok;
  assign is_fork   = accept && (cmd_op == OP_FORK);
  assign is_stop   = accept && (cmd_op == OP_STOP);
  assign is_post   = accept && (cmd_op == OP_POST) && frame_ok;
  assign is_swap   = accept && (cmd_op == OP_SWAP);

  assign take_q     = (is_swap || do_auto) && !q_empty;
  assign swap_empty = is_swap && q_empty;
  assign fork_ok    = is_fork && cur_valid_q;
  assign stop_ok    = is_stop && cur_valid_q && !st_empty[cur_frame_q];
  assign post_enq   = is_post && !queued_q[cmd_frame] &&
                      !(cur_valid_q && (cur_frame_q == cmd_frame));

  // one stack per frame
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    assign st_init[g] = is_falloc && (cmd_frame == FID_W'(g));
    assign st_push[g] = (fork_ok && (cur_frame_q == FID_W'(g))) ||
                        (is_post && (cmd_frame == FID_W'(g)));
    assign st_pop[g]  = (stop_ok && (cur_frame_q == FID_W'(g))) ||
                        (take_q && (q_head == FID_W'(g)));

    frame_stack #(
      .DEPTH (STACK_DEPTH),
      .PC_W  (PC_W)
    ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (st_init[g]),
      .init_pc (cmd_pc),
      .push    (st_push[g]),
      .push_pc (cmd_pc),
      .pop     (st_pop[g]),
      .top_pc  (st_top[g]),
      .empty   (st_empty[g]),
      .full    (st_full[g])
    );
  end

  run_queue #(
    .NUM  (NUM_FRAMES),
    .ID_W (FID_W)
  ) u_runq (
    .clk     (clk),
    .rst_n   (rst_n),
    .enq     (post_enq),
    .enq_id  (cmd_frame),
    .deq     (take_q),
    .head_id (q_head),
    .empty   (q_empty),
    .count   (q_count)
  );

  // dispatch register and frame selection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q        <= 1'b0;
      opc_q       <= '0;
      ofr_q       <= '0;
      cur_valid_q <= 1'b0;
      cur_frame_q <= '0;
      idle_q      <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      ovf_q <= |(st_push & st_full);
      if (stop_ok) begin
        ov_q  <= 1'b1;
        opc_q <= st_top[cur_frame_q];
        ofr_q <= cur_frame_q;
      end else if (take_q) begin
        ov_q  <= 1'b1;
        opc_q <= st_top[q_head];
        ofr_q <= q_head;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
      if (take_q) begin
        cur_valid_q <= 1'b1;
        cur_frame_q <= q_head;
        idle_q      <= 1'b0;
      end else if (swap_empty) begin
        cur_valid_q <= 1'b0;
        idle_q      <= 1'b1;
      end
    end
  end

  // queued marks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      queued_q <= '0;
    end else begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        if (post_enq && (cmd_frame == FID_W'(i)))
          queued_q[i] <= 1'b1;
        else if ((take_q && (q_head == FID_W'(i))) || st_init[i])
          queued_q[i] <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_pc    = opc_q;
  assign out_frame = ofr_q;
  assign idle      = idle_q;
  assign overflow  = ovf_q;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int NUM_FRAMES = 4,
  parameter int PC_W       = 16,
  parameter int FID_W      = 2,
  parameter int QC_W       = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [PC_W-1:0]       out_pc,
  input logic [FID_W-1:0]      out_frame,
  input logic                  idle,
  input logic                  overflow,
  input logic [NUM_FRAMES-1:0] queued,
  input logic [QC_W-1:0]       q_count
);
  // R9: a stalled dispatch is held
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_frame));

  // R9: no command taken while a dispatch waits
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);

  // R4: each queued mark matches exactly one queue slot
  p_queued_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(queued) == int'(q_count));

  // R6: a fresh dispatch always leaves the idle state
  p_idle_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !idle);

  // R7: overflow only follows an accepted command
  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(cmd_valid && cmd_ready));
endmodule

bind frame_sched sched_checker #(
  .NUM_FRAMES (NUM_FRAMES),
  .PC_W       (PC_W),
  .FID_W      (FID_W),
  .QC_W       (QC_W)
) u_sched_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pc    (out_pc),
  .out_frame (out_frame),
  .idle      (idle),
  .overflow  (overflow),
  .queued    (queued_q),
  .q_count   (q_count)
);

// File: tb/test_frame_sched.sv
module test_frame_sched;
  localparam int NF = 4;
  localparam int SD = 4;
  localparam int PW = 16;
  localparam int FW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [FW-1:0] cmd_frame = '0;
  logic [PW-1:0] cmd_pc = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_pc;
  logic [FW-1:0] out_frame;
  logic          idle;
  logic          overflow;

  always #5 clk = ~clk;

  frame_sched #(.NUM_FRAMES(NF), .STACK_DEPTH(SD), .PC_W(PW)) i_frame_sched (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_frame(cmd_frame), .cmd_pc(cmd_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
    .out_frame(out_frame), .idle(idle), .overflow(overflow));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [PW-1:0] m_stk [NF][SD];
  int            m_sp [NF];
  bit            m_qd [NF];
  int            m_q [$];
  int            m_cur = 0;
  bit            m_curv = 0;
  bit            m_idle = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      1: return "R2";
      2: return "R3";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic m_push(input int f, input logic [PW-1:0] pc, inout bit ovf);
    if (m_sp[f] == SD) ovf = 1'b1;
    else begin
      m_stk[f][m_sp[f]] = pc;
      m_sp[f]++;
    end
  endtask

  task automatic m_take(output logic [PW-1:0] pc, output int fr);
    int f = m_q.pop_front();
    m_qd[f] = 1'b0;
    m_cur = f;
    m_curv = 1'b1;
    m_idle = 1'b0;
    fr = f;
    pc = '0;
    if (m_sp[f] > 0) begin
      m_sp[f]--;
      pc = m_stk[f][m_sp[f]];
    end
  endtask

  task automatic model_step(input int op, input int f, input logic [PW-1:0] pc,
                            output bit eo, output logic [PW-1:0] epc, output int efr,
                            output bit eovf, output bit ea, output logic [PW-1:0] apc,
                            output int afr, output bit eidle);
    eo = 0; eovf = 0; ea = 0; epc = '0; efr = 0; apc = '0; afr = 0;
    case (op)
      1: begin m_stk[f][0] = pc; m_sp[f] = 1; m_qd[f] = 1'b0; end
      2: if (m_curv) m_push(m_cur, pc, eovf);
      3: if (m_curv && m_sp[m_cur] > 0) begin
           m_sp[m_cur]--;
           epc = m_stk[m_cur][m_sp[m_cur]];
           efr = m_cur;
           eo = 1'b1;
         end
      4: begin
           m_push(f, pc, eovf);
           if (!m_qd[f] && !(m_curv && m_cur == f)) begin
             m_qd[f] = 1'b1;
             m_q.push_back(f);
           end
         end
      5: if (m_q.size() > 0) begin m_take(epc, efr); eo = 1'b1; end
         else begin m_idle = 1'b1; m_curv = 1'b0; end
      default: ;
    endcase
    eidle = m_idle;
    if (m_idle && m_q.size() > 0) begin
      ea = 1'b1;
      m_take(apc, afr);
    end
  endtask

  // one command: drive, check its result, check any automatic dispatch
  task automatic issue(input int op, input int f, input logic [PW-1:0] pc, input string req);
    bit eo, eovf, ea, eidle;
    logic [PW-1:0] epc, apc;
    int efr, afr;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "cmd_ready before command", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_op = 3'(op);
    cmd_frame = FW'(f);
    cmd_pc = pc;
    model_step(op, f, pc, eo, epc, efr, eovf, ea, apc, afr, eidle);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(out_valid == eo, req, "out_valid", out_valid, eo);
    if (eo) begin
      chk(out_pc == epc, req, "out_pc", out_pc, epc);
      chk(out_frame == FW'(efr), req, "out_frame", out_frame, efr);
      chk(cmd_ready == 1'b0, "R9", "cmd_ready while output pending", cmd_ready, 0);
    end
    chk(overflow == eovf, "R7", "overflow", overflow, eovf);
    chk(idle == eidle, "R6", "idle after command", idle, eidle);
    @(negedge clk);
    chk(out_valid == ea, "R6", "automatic dispatch valid", out_valid, ea);
    if (ea) begin
      chk(out_pc == apc, "R6", "automatic dispatch pc", out_pc, apc);
      chk(out_frame == FW'(afr), "R6", "automatic dispatch frame", out_frame, afr);
      chk(idle == 1'b0, "R6", "idle after dispatch", idle, 0);
    end
    chk(overflow == 1'b0, "R7", "overflow pulse width", overflow, 0);
  endtask

  initial begin
    bit eo, eovf, ea, eidle;
    logic [PW-1:0] epc, apc;
    int efr, afr;
    for (int i = 0; i < NF; i++) begin m_sp[i] = 0; m_qd[i] = 0; end
    void'($urandom(32'd20260419));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(idle == 0, "R1", "idle", idle, 0);
    chk(overflow == 0, "R1", "overflow", overflow, 0);
    chk(cmd_ready == 1, "R1", "cmd_ready", cmd_ready, 1);

    // R8: nothing current yet
    issue(3, 0, 16'h0, "R8");
    issue(2, 0, 16'h0BAD, "R8");
    // R2/R4: allocate two frames, post twice to frame 0
    issue(1, 0, 16'h0E00, "R2");
    issue(4, 0, 16'h0100, "R4");
    issue(4, 0, 16'h0101, "R4");
    issue(1, 1, 16'h1E00, "R2");
    issue(4, 1, 16'h1100, "R4");
    issue(5, 0, 16'h0, "R5");          // frame 0, top 0101
    issue(2, 0, 16'h0200, "R3");
    issue(3, 0, 16'h0, "R3");          // 0200
    issue(4, 0, 16'h0300, "R10");      // post to current
    issue(3, 0, 16'h0, "R10");         // 0300
    issue(3, 0, 16'h0, "R3");          // 0100
    issue(3, 0, 16'h0, "R2");          // exit 0E00 last
    issue(3, 0, 16'h0, "R8");          // empty stack
    issue(5, 0, 16'h0, "R5");          // frame 1
    issue(3, 0, 16'h0, "R2");          // 1E00
    issue(5, 0, 16'h0, "R4");          // frame 0 queued once only: idle now
    issue(3, 0, 16'h0, "R8");
    issue(4, 2, 16'h2100, "R6");       // automatic dispatch
    // R7: fill frame 2, then one more
    for (int k = 0; k < SD + 1; k++) issue(2, 0, 16'h2200 + 16'(k), "R7");
    issue(3, 0, 16'h0, "R7");          // last stored push
    // R11: unused opcodes
    issue(6, 1, 16'h6666, "R11");
    issue(7, 1, 16'h7777, "R11");
    issue(0, 1, 16'h0, "R11");
    issue(3, 0, 16'h0, "R11");         // stack unchanged by them

    // R9: stall the output
    out_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3;
    model_step(3, 0, 16'h0, eo, epc, efr, eovf, ea, apc, afr, eidle);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid == eo, "R9", "held valid", out_valid, eo);
      chk(out_pc == epc, "R9", "held pc", out_pc, epc);
      chk(cmd_ready == 1'b0, "R9", "cmd_ready stalled", cmd_ready, 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "released", out_valid, 0);

    // constrained random
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 99);
      int f = $urandom_range(0, NF - 1);
      int op;
      logic [PW-1:0] pc = PW'($urandom());
      if (r < 10) op = 1;
      else if (r < 32) op = 2;
      else if (r < 60) op = 3;
      else if (r < 85) op = 4;
      else if (r < 96) op = 5;
      else op = 6 + (r & 1);
      if (op == 1 && (m_qd[f] || (m_curv && m_cur == f))) op = 4;
      issue(op, f, pc, tag_of(op));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule